// File: doc/BRIEF.md
# Elementary-Time-Unit Timeout and Guard Timer

This block supervises the timing of a smart-card link in elementary time units (ETUs). A prescaler outside the block produces a one-cycle `etu_tick` per ETU, and a receiver outside the block reports start bits and completed characters. The host writes a 24-bit reload value. It then starts the down-counter in one of two ways: by a command, to measure from a command such as the answer-to-reset window, or by every detected start bit, to measure character and block waiting times. When the count runs out, a sticky flag is set and an interrupt pulse is raised. The counter then stops, or reloads itself and continues if the host has enabled that.

A second, smaller counter enforces the protocol guard gap. Each received character loads it with 16 ETUs under T=0 or 22 ETUs under T=1. `tx_ready` stays low until that many ETUs have passed, so that the transmitter waits before it answers.

Top module: `etu_watchdog_timer`

## Requirements
- R1: After reset, `count` is 0, `running`, `timeout_flag` and `timeout_irq` are 0, and `tx_ready` is 1.
- R2: `sw_start` loads `count` from the reload register and sets `running` on the next cycle. When `arm_on_edge` is 0, `start_edge` has no effect.
- R3: While `running` is high, each cycle with `etu_tick` high lowers `count` by one. Cycles without a tick, and all cycles while stopped, leave `count` unchanged.
- R4: A tick while running with `count` at 1 or 0 is an expiry. On the next cycle `timeout_flag` is 1 and `timeout_irq` is 1, and `timeout_irq` returns to 0 after one cycle. The flag stays set until `flag_clr`. An expiry in the same cycle as `flag_clr` leaves the flag set.
- R5: On expiry with `auto_reload` at 0, the counter stops with `count` at 0. With `auto_reload` at 1, it reloads `count` from the reload register and keeps running.
- R6: When `arm_on_edge` is 1, each `start_edge` reloads `count` and sets `running`, including while the counter is already running.
- R7: `sw_stop` clears `running` and holds `count`. It overrides a start in the same cycle.
- R8: Writing the reload register while running leaves the current count alone. The new value is used at the next start or auto-reload. A start in the same cycle as a write uses the previous value.
- R9: `rx_char_done` loads the guard counter with 22 when `proto_t1` is 1 and with 16 when it is 0, and `tx_ready` goes low on the next cycle. Each tick lowers the guard count, and `tx_ready` returns high on the cycle after the tick that brings it to 0. A new `rx_char_done` restarts the gap and overrides a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| etu_tick | input | 1 | One-cycle strobe per elementary time unit |
| start_edge | input | 1 | Start bit detected on the card line |
| sw_start | input | 1 | Command start of the timeout counter |
| sw_stop | input | 1 | Command stop of the timeout counter |
| arm_on_edge | input | 1 | 1: every start bit restarts the counter |
| auto_reload | input | 1 | 1: reload and continue after expiry |
| reload_we | input | 1 | Write strobe for the reload register |
| reload_val | input | 24 | Reload value in ETUs |
| flag_clr | input | 1 | Clears the sticky timeout flag |
| rx_char_done | input | 1 | A character has been received; starts the guard gap |
| proto_t1 | input | 1 | 1: T=1 guard length, 0: T=0 guard length |
| count | output | 24 | Current timeout count |
| running | output | 1 | Timeout counter is active |
| timeout_flag | output | 1 | Sticky expiry flag |
| timeout_irq | output | 1 | One-cycle interrupt pulse on expiry |
| tx_ready | output | 1 | Guard gap has elapsed; transmission allowed |

## Verification
The properties assume that every control input is a level sampled on the rising clock edge, with no meaning attached to its duration. A strobe held high for several cycles therefore acts once per cycle. The properties also rely on the stated priorities: stop over start, start over expiry, and guard reload over tick. The stimulus changes inputs only on the falling edge. It applies directed pulses one cycle long and then a long random phase in which starts, stops, reload writes, flag clears, ticks and protocol changes collide in every combination. Reload values stay small in that phase so that expiries, auto-reloads and write-while-running cases occur often.

// File: rtl/etu_pkg.sv
package etu_pkg;

  localparam int unsigned ETU_CNT_W_DEF = 24;
  localparam int unsigned GUARD_T0_DEF  = 16;
  localparam int unsigned GUARD_T1_DEF  = 22;

  // Larger of two guard lengths, used to size the guard counter.
  function automatic int unsigned max_len(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // A tick that meets a count of one or zero ends the period.
  function automatic logic is_last_unit(input logic [ETU_CNT_W_DEF-1:0] cnt);
    return (cnt <= 1);
  endfunction

endpackage

// File: rtl/etu_reload_reg.sv
module etu_reload_reg #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= din;
  end
endmodule

// File: rtl/etu_down_counter.sv
module etu_down_counter #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic         halt,
  input  logic         auto_reload,
  input  logic [W-1:0] reload_q,
  output logic [W-1:0] count,
  output logic         running,
  output logic         expire
);
  logic last_unit;

  assign last_unit = (count <= W'(1));
  assign expire    = running && tick && !halt && !load && last_unit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (halt) begin
      running <= 1'b0;
    end else if (load) begin
      count   <= reload_q;
      running <= 1'b1;
    end else if (expire) begin
      if (auto_reload) begin
        count <= reload_q;
      end else begin
        count   <= '0;
        running <= 1'b0;
      end
    end else if (running && tick) begin
      count <= count - W'(1);
    end
  end
endmodule

// File: rtl/etu_timeout_flag.sv
module etu_timeout_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= expire;
      if (expire)   flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/etu_guard_counter.sv
module etu_guard_counter #(
  parameter int unsigned T0_LEN = 16,
  parameter int unsigned T1_LEN = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  input  logic proto_t1,
  output logic tx_ready
);
  localparam int unsigned GW = $clog2(etu_pkg::max_len(T0_LEN, T1_LEN) + 1);

  logic [GW-1:0] len;
  logic [GW-1:0] gcnt;

  generate
    if (T0_LEN == T1_LEN) begin : g_single
      assign len = GW'(T0_LEN);
    end else begin : g_dual
      assign len = proto_t1 ? GW'(T1_LEN) : GW'(T0_LEN);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gcnt <= '0;
    else if (arm)                    gcnt <= len;
    else if (tick && gcnt != '0)     gcnt <= gcnt - GW'(1);
  end

  assign tx_ready = (gcnt == '0);
endmodule

// File: rtl/etu_watchdog_timer.sv
module etu_watchdog_timer #(
  parameter int unsigned CNT_W    = etu_pkg::ETU_CNT_W_DEF,
  parameter int unsigned GUARD_T0 = etu_pkg::GUARD_T0_DEF,
  parameter int unsigned GUARD_T1 = etu_pkg::GUARD_T1_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             etu_tick,
  input  logic             start_edge,
  input  logic             sw_start,
  input  logic             sw_stop,
  input  logic             arm_on_edge,
  input  logic             auto_reload,
  input  logic             reload_we,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             flag_clr,
  input  logic             rx_char_done,
  input  logic             proto_t1,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             timeout_flag,
  output logic             timeout_irq,
  output logic             tx_ready
);
  logic [CNT_W-1:0] reload_q;
  logic             load_evt;
  logic             expire_evt;

  // Stop dominates any start request in the same cycle.
  assign load_evt = !sw_stop && (sw_start || (arm_on_edge && start_edge));

  etu_reload_reg #(.W(CNT_W)) u_reload (
    .clk(clk), .rst_n(rst_n), .we(reload_we), .din(reload_val), .q(reload_q)
  );

  etu_down_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(etu_tick), .load(load_evt), .halt(sw_stop),
    .auto_reload(auto_reload), .reload_q(reload_q),
    .count(count), .running(running), .expire(expire_evt)
  );

  etu_timeout_flag u_flag (
    .clk(clk), .rst_n(rst_n), .expire(expire_evt), .clr(flag_clr),
    .flag(timeout_flag), .irq(timeout_irq)
  );

  etu_guard_counter #(.T0_LEN(GUARD_T0), .T1_LEN(GUARD_T1)) u_guard (
    .clk(clk), .rst_n(rst_n), .tick(etu_tick), .arm(rx_char_done),
    .proto_t1(proto_t1), .tx_ready(tx_ready)
  );
endmodule

// File: rtl/etu_watchdog_chk.sv
module etu_watchdog_chk #(
  parameter int unsigned W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         etu_tick,
  input logic         start_edge,
  input logic         sw_start,
  input logic         sw_stop,
  input logic         arm_on_edge,
  input logic         auto_reload,
  input logic         flag_clr,
  input logic         rx_char_done,
  input logic [W-1:0] count,
  input logic         running,
  input logic         timeout_flag,
  input logic         timeout_irq,
  input logic         tx_ready,
  input logic         load_evt,
  input logic         expire_evt
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !load_evt |=> $stable(count) && !running); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    running && etu_tick && !sw_stop && !load_evt && count > W'(1) |=> count == $past(count) - W'(1)); // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    running && !etu_tick && !sw_stop && !load_evt |=> $stable(count) && running); // R3
  AST_LOAD_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> running); // R2
  AST_EDGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_on_edge && start_edge && !sw_start && !running |=> !running); // R2
  AST_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> timeout_flag && timeout_irq); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag && !flag_clr |=> timeout_flag); // R4
  AST_IRQ_ONLY_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !expire_evt |=> !timeout_irq); // R4
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt && !auto_reload |=> !running && count == '0); // R5
  AST_AUTO_CONTINUE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt && auto_reload |=> running); // R5
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stop |=> !running && $stable(count)); // R7
  AST_GUARD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_char_done |=> !tx_ready); // R9
  AST_GUARD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(etu_tick) && !$past(rx_char_done)); // R9
endmodule

bind etu_watchdog_timer etu_watchdog_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .start_edge(start_edge),
  .sw_start(sw_start), .sw_stop(sw_stop), .arm_on_edge(arm_on_edge),
  .auto_reload(auto_reload), .flag_clr(flag_clr), .rx_char_done(rx_char_done),
  .count(count), .running(running), .timeout_flag(timeout_flag),
  .timeout_irq(timeout_irq), .tx_ready(tx_ready),
  .load_evt(load_evt), .expire_evt(expire_evt)
);

// File: tb/sim_etu_watchdog_timer.sv
`timescale 1ns/1ps
module sim_etu_watchdog_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        etu_tick = 0, start_edge = 0, sw_start = 0, sw_stop = 0;
  logic        arm_on_edge = 0, auto_reload = 0, reload_we = 0, flag_clr = 0;
  logic        rx_char_done = 0, proto_t1 = 0;
  logic [23:0] reload_val = '0;
  logic [23:0] count;
  logic        running, timeout_flag, timeout_irq, tx_ready;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  etu_watchdog_timer u0 (
    .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .start_edge(start_edge),
    .sw_start(sw_start), .sw_stop(sw_stop), .arm_on_edge(arm_on_edge),
    .auto_reload(auto_reload), .reload_we(reload_we), .reload_val(reload_val),
    .flag_clr(flag_clr), .rx_char_done(rx_char_done), .proto_t1(proto_t1),
    .count(count), .running(running), .timeout_flag(timeout_flag),
    .timeout_irq(timeout_irq), .tx_ready(tx_ready)
  );

  // Behavioural reference
  longint m_reload, m_cnt, m_guard;
  bit     m_run, m_flag, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reload = 0; m_cnt = 0; m_guard = 0; m_run = 0; m_flag = 0; m_irq = 0;
    end else begin
      bit start_req, expired;
      start_req = sw_start || (arm_on_edge && start_edge);
      expired = 0;
      if (sw_stop) m_run = 0;
      else if (start_req) begin m_cnt = m_reload; m_run = 1; end
      else if (m_run && etu_tick) begin
        if (m_cnt <= 1) begin
          expired = 1;
          if (auto_reload) m_cnt = m_reload;
          else begin m_cnt = 0; m_run = 0; end
        end else m_cnt = m_cnt - 1;
      end
      m_irq = expired;
      if (expired) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (reload_we) m_reload = reload_val;
      if (rx_char_done) m_guard = proto_t1 ? 22 : 16;
      else if (etu_tick && m_guard > 0) m_guard = m_guard - 1;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 count",   count,        m_cnt);
      check("R5 running", running,      m_run);
      check("R4 flag",    timeout_flag, m_flag);
      check("R4 irq",     timeout_irq,  m_irq);
      check("R9 tx_ready", tx_ready,    (m_guard == 0));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    check("R1 count", count, 0); check("R1 running", running, 0);
    check("R1 flag", timeout_flag, 0); check("R1 irq", timeout_irq, 0);
    check("R1 tx_ready", tx_ready, 1);

    // R2 software start
    reload_we = 1; reload_val = 5; step(1); reload_we = 0;
    sw_start = 1; step(1); sw_start = 0;
    check("R2 running", running, 1); check("R2 count", count, 5);
    etu_tick = 1; step(2); etu_tick = 0; step(3);
    check("R3 count after gaps", count, 3);
    etu_tick = 1; step(3); etu_tick = 0;
    check("R4 flag", timeout_flag, 1); check("R4 irq", timeout_irq, 1);
    check("R5 stopped", running, 0); check("R5 zero", count, 0);
    step(1);
    check("R4 irq pulse ends", timeout_irq, 0); check("R4 flag sticky", timeout_flag, 1);
    flag_clr = 1; step(1); flag_clr = 0;
    check("R4 flag cleared", timeout_flag, 0);
    start_edge = 1; step(1); start_edge = 0;
    check("R2 edge ignored in sw mode", running, 0);

    // R6 edge mode
    arm_on_edge = 1;
    reload_we = 1; reload_val = 10; step(1); reload_we = 0;
    start_edge = 1; step(1); start_edge = 0;
    check("R6 edge start", count, 10); check("R6 running", running, 1);
    etu_tick = 1; step(4); etu_tick = 0;
    check("R6 counted", count, 6);
    start_edge = 1; step(1); start_edge = 0;
    check("R6 restart", count, 10);

    // R8 reload write while running
    reload_we = 1; reload_val = 3; step(1); reload_we = 0;
    check("R8 count unaffected", count, 10);
    etu_tick = 1; step(1); etu_tick = 0;
    check("R8 still old", count, 9);
    sw_start = 1; step(1); sw_start = 0;
    check("R8 new value at start", count, 3);

    // R7 stop
    etu_tick = 1; step(1); etu_tick = 0;
    sw_stop = 1; step(1); sw_stop = 0;
    check("R7 stopped", running, 0); check("R7 held", count, 2);
    etu_tick = 1; step(2); etu_tick = 0;
    check("R7 held after ticks", count, 2);
    sw_stop = 1; sw_start = 1; step(1); sw_stop = 0; sw_start = 0;
    check("R7 stop beats start", running, 0);
    arm_on_edge = 0;

    // R5 auto-reload
    auto_reload = 1;
    sw_start = 1; step(1); sw_start = 0;
    etu_tick = 1; step(3); etu_tick = 0;
    check("R5 auto count", count, 3); check("R5 auto running", running, 1);
    check("R4 irq on auto", timeout_irq, 1);
    auto_reload = 0;

    // R4 expiry beats clear
    sw_start = 1; step(1); sw_start = 0;
    etu_tick = 1; step(2);
    flag_clr = 1; step(1); flag_clr = 0; etu_tick = 0;
    check("R4 set wins over clear", timeout_flag, 1);
    flag_clr = 1; step(1); flag_clr = 0;
    check("R4 cleared", timeout_flag, 0);

    // R9 guard times
    proto_t1 = 0; rx_char_done = 1; step(1); rx_char_done = 0;
    check("R9 blocked T0", tx_ready, 0);
    etu_tick = 1; step(15);
    check("R9 T0 before end", tx_ready, 0);
    step(1); etu_tick = 0;
    check("R9 T0 released", tx_ready, 1);
    proto_t1 = 1; rx_char_done = 1; step(1); rx_char_done = 0;
    etu_tick = 1; step(21);
    check("R9 T1 before end", tx_ready, 0);
    step(1);
    check("R9 T1 released", tx_ready, 1);
    rx_char_done = 1; step(1); rx_char_done = 0;
    step(10);
    rx_char_done = 1; step(1); rx_char_done = 0;
    step(21);
    check("R9 retrigger pending", tx_ready, 0);
    step(1); etu_tick = 0;
    check("R9 retrigger released", tx_ready, 1);

    // Random collisions
    for (int i = 0; i < 4000; i++) begin
      etu_tick     = ($urandom % 2) == 0;
      start_edge   = ($urandom % 20) == 0;
      sw_start     = ($urandom % 60) == 0;
      sw_stop      = ($urandom % 80) == 0;
      reload_we    = ($urandom % 30) == 0;
      reload_val   = 24'($urandom % 12);
      flag_clr     = ($urandom % 25) == 0;
      rx_char_done = ($urandom % 40) == 0;
      if (($urandom % 200) == 0) arm_on_edge = ~arm_on_edge;
      if (($urandom % 200) == 0) auto_reload = ~auto_reload;
      if (($urandom % 100) == 0) proto_t1 = ~proto_t1;
      step(1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule